// File: doc/BRIEF.md
# Asynchronous Bus Memory Responder

This block is the memory-side target of an interlocked, fully handshaked asynchronous bus. The requester sets up an address, a direction bit and a memory-select strobe, and then raises a request strobe that says those signals are now trustworthy. The responder brings the request strobe into its own clock domain through a flop synchronizer. It ignores any cycle whose memory-select is low. After a fixed processing delay, counted in clock cycles, it serves the access from an internal word array. A read puts the addressed word on the data bus and drives it. One clock later the responder raises its acknowledge strobe, which certifies that word.

The acknowledge and the driven data stay put until the requester withdraws its request strobe. The responder then drops the acknowledge first and releases the data drivers one clock later. After that, every bus signal is back at idle and a new cycle may begin at once. A write stores the bus data into the addressed word before the acknowledge rises, and it never drives the data bus. There is no valid/ready stream here. Back-pressure is the handshake itself: neither side moves on until it sees the other's strobe change, so a slow requester simply holds the acknowledge high for as long as it needs.

Top module: `async_mem_responder`

## Requirements
- R1: While reset is asserted and directly after it, `ssync_o` is 0 and `data_oe_o` is 0.
- R2: A cycle with `mreq_i` low is ignored. `ssync_o` and `data_oe_o` stay 0 for as long as `msync_i` is high, and the array keeps its contents.
- R3: Suppose `msync_i` (with `mreq_i` high) is seen high at clock edge E0. For a read, `data_oe_o` first reads 1 after edge E0+DELAY+2, and `ssync_o` first reads 1 after edge E0+DELAY+3. Neither is 1 earlier.
- R4: On a read, `data_o` equals the addressed array word from the cycle in which `data_oe_o` rises, which is one cycle before `ssync_o` rises.
- R5: While `ssync_o` is 1 on a read, `data_oe_o` is 1 and `data_o` does not change.
- R6: Suppose `msync_i` is seen low at edge F0 while `ssync_o` is 1. Then `ssync_o` reads 0 after edge F0+2, and `data_oe_o` stays 1 until it reads 0 after edge F0+3. Before F0+2, `ssync_o` stays 1.
- R7: A write (`wr_i`=1) stores `data_i` at `addr_i` before `ssync_o` rises, on the same schedule as R3. `data_oe_o` stays 0 throughout the write. A later read of that address returns the stored word.
- R8: After reset, every array word reads as zero.
- R9: Direction encoding: `wr_i`=0 selects a read and `wr_i`=1 selects a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Responder clock |
| rst_n | input | 1 | Active-low reset |
| msync_i | input | 1 | Request-valid strobe from the requester (asynchronous) |
| mreq_i | input | 1 | Memory select; a cycle is served only when high |
| wr_i | input | 1 | Direction: 0 read, 1 write |
| addr_i | input | AW | Word address |
| data_i | input | DW | Data bus as seen by the responder (write data) |
| data_o | output | DW | Read data driven toward the bus |
| data_oe_o | output | 1 | Enable for the data-bus drivers |
| ssync_o | output | 1 | Acknowledge strobe certifying the response |

## Verification
The result times are set by the two synchronizer flops, the DELAY-cycle wait, one settle cycle and one release cycle. Counting from the first edge that sees the request strobe high, the driver enable is due after DELAY+2 edges and the acknowledge after DELAY+3. Counting from the first edge that sees the strobe low, the acknowledge falls after 2 edges and the enable after 3. The scenario tasks change inputs only on falling clock edges and count rising edges from there. They sample each output one edge before and exactly at its due edge, so an early or late change is caught. Read data is checked at the enable edge and again on every cycle the acknowledge is held high.

// File: rtl/amr_pkg.sv
package amr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETTLE,
    ST_ACK,
    ST_RELEASE
  } resp_state_e;
endpackage

// File: rtl/amr_sync.sv
module amr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/amr_delay.sv
module amr_delay #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] START = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= START;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;

  assign expired_o = (cnt_q == '0);

  // R3: a fresh load never lands on a counter that is still running down
  // (a running count means that the responder is not idle)
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/amr_array.sv
module amr_array #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/async_mem_responder.sv
module async_mem_responder
  import amr_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter int DELAY       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msync_i,
  input  logic          mreq_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          ssync_o
);
  resp_state_e   state_q;
  logic          msync_s;
  logic          expired;
  logic          accept;
  logic          commit;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] dout_q;
  logic          oe_q;
  logic          ssync_q;

  amr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(msync_i), .q_o(msync_s)
  );

  assign accept = (state_q == ST_IDLE) && msync_s && mreq_i;
  assign commit = (state_q == ST_WAIT) && expired;

  amr_delay #(.DELAY(DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .expired_o(expired)
  );

  amr_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .we_i(commit && wr_q),
    .addr_i(addr_q), .wdata_i(wdata_q), .rdata_o(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      dout_q  <= '0;
      oe_q    <= 1'b0;
      ssync_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_WAIT;
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= data_i;
        end
        ST_WAIT: if (expired) begin
          state_q <= ST_SETTLE;
          if (!wr_q) begin
            dout_q <= rd_word;
            oe_q   <= 1'b1;
          end
        end
        ST_SETTLE: begin
          state_q <= ST_ACK;
          ssync_q <= 1'b1;
        end
        ST_ACK: if (!msync_s) begin
          state_q <= ST_RELEASE;
          ssync_q <= 1'b0;
        end
        ST_RELEASE: begin
          state_q <= ST_IDLE;
          oe_q    <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end

  assign data_o    = dout_q;
  assign data_oe_o = oe_q;
  assign ssync_o   = ssync_q;

  // R5
  oe_covers_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ssync_o && !wr_q) |-> data_oe_o);
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ssync_o && $past(ssync_o)) |-> $stable(data_o));
  // R6
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ssync_o) && data_oe_o) |=> !data_oe_o);
  // R4
  drive_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ssync_o) && !wr_q) |-> $past(data_oe_o));
  // R3
  start_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> !ssync_o);
  // R7
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ssync_o && wr_q) |-> !data_oe_o);
  // R6
  hold_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ssync_o && msync_s) |=> ssync_o);
endmodule

// File: tb/tb_async_mem_responder.sv
module tb_async_mem_responder;
  localparam int AW  = 4;
  localparam int DW  = 16;
  localparam int DLY = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msync_i = 1'b0;
  logic          mreq_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic          ssync_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  async_mem_responder #(.AW(AW), .DW(DW), .DELAY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .msync_i(msync_i), .mreq_i(mreq_i),
    .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .ssync_o(ssync_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Withdraw the request and check the release order
  task automatic release_req(input logic was_read, input string tag);
    msync_i = 1'b0;
    tick(2);
    chk({tag, " R6 ack held before F0+2"}, ssync_o, 1);
    tick(1);
    chk({tag, " R6 ack low after F0+2"}, ssync_o, 0);
    chk({tag, " R6 oe held one more cycle"}, data_oe_o, was_read);
    tick(1);
    chk({tag, " R6 oe low after F0+3"}, data_oe_o, 0);
    mreq_i = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    mreq_i = 1'b1; wr_i = 1'b0; addr_i = a; msync_i = 1'b1;
    tick(DLY + 2);
    chk({tag, " R3 oe not early"}, data_oe_o, 0);
    tick(1);
    chk({tag, " R3 oe at E0+D+2"}, data_oe_o, 1);
    chk({tag, " R3 ack not early"}, ssync_o, 0);
    chk({tag, " R4 data at oe rise"}, data_o, exp);
    tick(1);
    chk({tag, " R3 ack at E0+D+3"}, ssync_o, 1);
    for (int i = 0; i < 3; i++) begin
      chk({tag, " R5 data held"}, data_o, exp);
      chk({tag, " R5 oe held"}, data_oe_o, 1);
      tick(1);
    end
    release_req(1'b1, tag);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    mreq_i = 1'b1; wr_i = 1'b1; addr_i = a; data_i = d; msync_i = 1'b1;
    tick(DLY + 3);
    chk({tag, " R7 no drive on write"}, data_oe_o, 0);
    chk({tag, " R7 ack not early"}, ssync_o, 0);
    tick(1);
    chk({tag, " R7 ack at E0+D+3"}, ssync_o, 1);
    chk({tag, " R7 no drive during ack"}, data_oe_o, 0);
    release_req(1'b0, tag);
    wr_i = 1'b0;
  endtask

  task automatic ignored_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mreq_i = 1'b0; wr_i = 1'b1; addr_i = a; data_i = d; msync_i = 1'b1;
    for (int i = 0; i < DLY + 6; i++) begin
      tick(1);
      chk("R2 no ack without mreq", ssync_o, 0);
      chk("R2 no drive without mreq", data_oe_o, 0);
    end
    msync_i = 1'b0; wr_i = 1'b0;
    tick(4);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 ack low in reset", ssync_o, 0);
    chk("R1 oe low in reset", data_oe_o, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 ack low after reset", ssync_o, 0);
    chk("R1 oe low after reset", data_oe_o, 0);

    do_read(4'd3, 16'h0000, "R8 zero word");
    do_write(4'd5, 16'hA5C3, "R9 write dir");
    do_read(4'd5, 16'hA5C3, "R7 readback");
    do_write(4'd15, 16'hFFFF, "R7 top word");
    do_read(4'd15, 16'hFFFF, "R9 read dir");
    ignored_cycle(4'd5, 16'h1111);
    do_read(4'd5, 16'hA5C3, "R2 word kept");
    do_read(4'd0, 16'h0000, "R8 word zero");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule